// File: doc/BRIEF.md
# Offset-Compensated Quadrature Modulator

This block synthesizes a modulated carrier as a stream of unsigned DAC codes, one per clock. A 32-bit phase accumulator steps by a tuning word every cycle. Its upper bits address a computed sine table, which supplies a sine and a cosine (a quarter turn later). A signed in-phase coefficient scales the sine and a signed quadrature coefficient scales the cosine. Together the two coefficients set the amplitude and phase of the carrier.

The table holds offset-binary codes, as an unsigned converter expects. Scaling those codes also scales their DC level. A third multiply lane therefore multiplies a derived offset coefficient by a fixed mid-code. This restores the mean to mid-scale for any coefficient pair. All three lanes have the same four-clock latency, so a new amplitude and its matching offset correction reach the output on the same clock.

Software-side logic first writes a tuning word and both coefficients into a shadow set, which computes the offset at the same time. It then issues a single commit that swaps the whole set in at once. The summed result is clamped to the converter range.

Top module: `iq_offset_mod`

## Requirements
- R1: While reset is held, and on the first five clocks after release, `dac_code` is 8192, which is mid-scale for the default 14-bit output. After reset the active set is zero (tuning word, I, Q) and the phase is zero.
- R2: On every clock the phase register grows by the active tuning word, modulo 2^32. Bits 31:22 of the phase form the 10-bit table index p.
- R3: The signed table value is s(k) = m for k < 512 and s(k) = -m for k >= 512, where x = k mod 512 and m = floor(x*(512-x)*127 / 65536). The cosine value is c(k) = s((k+256) mod 1024).
- R4: With no clamping, `dac_code` = 8192 + I*s(p) + Q*c(p). The offset lane carries the coefficient 64-(I+Q) times 128, so the DC term cancels for every I and Q.
- R5: Take the phase register after clock m-1 and the active set after clock m. The sample built from them appears on `dac_code` after clock m+5.
- R6: A clock with `stage_en` high copies `tune_word`, `i_coef` and `q_coef` into the shadow set. Staging alone leaves every later output unchanged.
- R7: A clock with `commit_en` high copies the whole shadow set (tuning word, I, Q, offset) into the active set on that one edge. No output sample mixes an old and a new value.
- R8: When `stage_en` and `commit_en` are high on the same clock, the active set receives the shadow contents from before that clock, and the new inputs stay in the shadow set.
- R9: A sum below 0 gives `dac_code` = 0, and a sum above 16383 gives 16383. There is no wrap.
- R10: With step 2^22 (one table entry per clock) and no clamping, any 1024 consecutive outputs under one active set add up to exactly 1024*8192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stage_en | input | 1 | Writes tune_word, i_coef, q_coef into the shadow set |
| commit_en | input | 1 | Moves the shadow set into the active set |
| tune_word | input | 32 | Phase increment per clock |
| i_coef | input | 8 | Signed in-phase (sine) coefficient |
| q_coef | input | 8 | Signed quadrature (cosine) coefficient |
| dac_code | output | 14 | Unsigned converter sample |

## Verification
The assertions assume three things about the inputs. Reset is low from time zero for several clocks. `stage_en` and `commit_en` are clean synchronous levels sampled at the rising edge. The data inputs never carry unknown values when a strobe is high. The stimulus changes every input only on falling edges, and it holds reset from the start of time, both at power-up and when reset is applied again mid-run. It drives the data inputs to defined values before any strobe, so the phase and shadow checks never see an undefined tuning word.

// File: rtl/iqm_pkg.sv
package iqm_pkg;

    localparam int NUM_LANES = 3;

    typedef enum int {
        LANE_SIN = 0,
        LANE_COS = 1,
        LANE_DC  = 2
    } lane_e;

    // Offset-binary wave code: parabolic half-cycles, positive half first.
    function automatic int unsigned wave_code(int unsigned idx, int unsigned aw, int unsigned dw);
        int unsigned half;
        int unsigned x;
        int unsigned amp;
        int unsigned mag;
        half = 1 << (aw - 1);
        x    = idx % half;
        amp  = (1 << (dw - 1)) - 1;
        mag  = (x * (half - x) * amp) >> (2 * aw - 4);
        if (idx >= half)
            return (1 << (dw - 1)) - mag;
        return (1 << (dw - 1)) + mag;
    endfunction

endpackage

// File: rtl/iqm_phase_acc.sv
module iqm_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int IDX_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] ftw_i,
    output logic [IDX_W-1:0]   idx_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d       = acc_q;
        acc_d.phase = acc_q.phase + ftw_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign idx_o = acc_q.phase[PHASE_W-1 -: IDX_W];

    // R2: the phase advances by exactly the tuning word seen on the prior clock
    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q.phase == $past(acc_q.phase) + $past(ftw_i));

endmodule

// File: rtl/iqm_wave_rom.sv
module iqm_wave_rom #(
    parameter int IDX_W  = 10,
    parameter int SAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [SAMP_W-1:0] sin_o,
    output logic [SAMP_W-1:0] cos_o
);

    localparam int DEPTH    = 2 ** IDX_W;
    localparam int QUARTER  = 2 ** (IDX_W - 2);
    localparam int MID_CODE = 2 ** (SAMP_W - 1);

    typedef struct packed {
        logic [SAMP_W-1:0] s;
        logic [SAMP_W-1:0] c;
    } rd_t;

    logic [SAMP_W-1:0] rom [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_rom
        assign rom[k] = SAMP_W'(iqm_pkg::wave_code(k, IDX_W, SAMP_W));
    end

    logic [IDX_W-1:0] cos_idx;
    rd_t rd_d, rd_q;

    always_comb begin
        cos_idx = idx_i + IDX_W'(QUARTER);
        rd_d.s  = rom[idx_i];
        rd_d.c  = rom[cos_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '{s: SAMP_W'(MID_CODE), c: SAMP_W'(MID_CODE)};
        else        rd_q <= rd_d;
    end

    assign sin_o = rd_q.s;
    assign cos_o = rd_q.c;

endmodule

// File: rtl/iqm_mac_lane.sv
module iqm_mac_lane #(
    parameter int CW      = 16,
    parameter int SW      = 8,
    parameter int LAT     = 4,
    parameter int RST_VAL = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [CW-1:0] coef_i,
    input  logic [SW-1:0]        samp_i,
    output logic signed [CW+SW:0] prod_o
);

    localparam int PW = CW + SW + 1;

    logic signed [PW-1:0] pipe_d [LAT];
    logic signed [PW-1:0] pipe_q [LAT];

    always_comb begin
        pipe_d[0] = PW'(coef_i) * PW'($signed({1'b0, samp_i}));
        for (int k = 1; k < LAT; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) pipe_q[k] <= PW'(RST_VAL);
        end else begin
            for (int k = 0; k < LAT; k++) pipe_q[k] <= pipe_d[k];
        end
    end

    assign prod_o = pipe_q[LAT-1];

endmodule

// File: rtl/iqm_coef_bank.sv
module iqm_coef_bank #(
    parameter int PHASE_W = 32,
    parameter int COEF_W  = 8,
    parameter int OFS_W   = 16,
    parameter int BASE    = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stage_i,
    input  logic                     commit_i,
    input  logic [PHASE_W-1:0]       ftw_i,
    input  logic [COEF_W-1:0]        i_i,
    input  logic [COEF_W-1:0]        q_i,
    output logic [PHASE_W-1:0]       ftw_o,
    output logic signed [COEF_W-1:0] i_o,
    output logic signed [COEF_W-1:0] q_o,
    output logic signed [OFS_W-1:0]  off_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] ftw;
        logic [COEF_W-1:0]  ci;
        logic [COEF_W-1:0]  cq;
        logic [OFS_W-1:0]   off;
    } set_t;

    typedef struct packed {
        set_t shd;
        set_t act;
    } bank_t;

    localparam set_t RST_SET = '{ftw: '0, ci: '0, cq: '0, off: OFS_W'(BASE)};

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (commit_i) bank_d.act = bank_q.shd;
        if (stage_i) begin
            bank_d.shd.ftw = ftw_i;
            bank_d.shd.ci  = i_i;
            bank_d.shd.cq  = q_i;
            bank_d.shd.off = OFS_W'(BASE) - OFS_W'($signed(i_i)) - OFS_W'($signed(q_i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '{shd: RST_SET, act: RST_SET};
        else        bank_q <= bank_d;
    end

    assign ftw_o = bank_q.act.ftw;
    assign i_o   = $signed(bank_q.act.ci);
    assign q_o   = $signed(bank_q.act.cq);
    assign off_o = $signed(bank_q.act.off);

    // R6: without a commit the active set never moves
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(bank_q.act));

    // R7: a commit moves the entire shadow set on one edge
    p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> bank_q.act == $past(bank_q.shd));

    // R4: active offset plus both amplitudes always balances to the base
    p_offset_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (OFS_W'($signed(bank_q.act.off)) + OFS_W'($signed(bank_q.act.ci))
         + OFS_W'($signed(bank_q.act.cq))) == OFS_W'(BASE));

endmodule

// File: rtl/iq_offset_mod.sv
module iq_offset_mod #(
    parameter int PHASE_W  = 32,
    parameter int IDX_W    = 10,
    parameter int SAMP_W   = 8,
    parameter int COEF_W   = 8,
    parameter int DAC_W    = 14,
    parameter int LANE_LAT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stage_en,
    input  logic               commit_en,
    input  logic [PHASE_W-1:0] tune_word,
    input  logic [COEF_W-1:0]  i_coef,
    input  logic [COEF_W-1:0]  q_coef,
    output logic [DAC_W-1:0]   dac_code
);

    import iqm_pkg::*;

    localparam int OFS_W    = COEF_W + DAC_W - SAMP_W + 2;
    localparam int PROD_W   = OFS_W + SAMP_W + 1;
    localparam int SUM_W    = PROD_W + 2;
    localparam int BASE     = 2 ** (DAC_W - SAMP_W);
    localparam int MID      = 2 ** (DAC_W - 1);
    localparam int DAC_MAX  = 2 ** DAC_W - 1;
    localparam int DC_SAMP  = 2 ** (SAMP_W - 1);

    logic [PHASE_W-1:0]       act_ftw;
    logic signed [COEF_W-1:0] act_i, act_q;
    logic signed [OFS_W-1:0]  act_off;
    logic [IDX_W-1:0]         idx;
    logic [SAMP_W-1:0]        sin_u, cos_u;

    iqm_coef_bank #(
        .PHASE_W(PHASE_W), .COEF_W(COEF_W), .OFS_W(OFS_W), .BASE(BASE)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .stage_i(stage_en), .commit_i(commit_en),
        .ftw_i(tune_word), .i_i(i_coef), .q_i(q_coef),
        .ftw_o(act_ftw), .i_o(act_i), .q_o(act_q), .off_o(act_off)
    );

    iqm_phase_acc #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .ftw_i(act_ftw), .idx_o(idx)
    );

    iqm_wave_rom #(.IDX_W(IDX_W), .SAMP_W(SAMP_W)) u_rom (
        .clk(clk), .rst_n(rst_n), .idx_i(idx), .sin_o(sin_u), .cos_o(cos_u)
    );

    logic signed [OFS_W-1:0]  lane_coef [NUM_LANES];
    logic [SAMP_W-1:0]        lane_samp [NUM_LANES];
    logic signed [PROD_W-1:0] lane_prod [NUM_LANES];

    always_comb begin
        lane_coef[LANE_SIN] = OFS_W'(act_i);
        lane_coef[LANE_COS] = OFS_W'(act_q);
        lane_coef[LANE_DC]  = act_off;
        lane_samp[LANE_SIN] = sin_u;
        lane_samp[LANE_COS] = cos_u;
        lane_samp[LANE_DC]  = SAMP_W'(DC_SAMP);
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        iqm_mac_lane #(
            .CW(OFS_W), .SW(SAMP_W), .LAT(LANE_LAT),
            .RST_VAL((l == LANE_DC) ? MID : 0)
        ) u_lane (
            .clk(clk), .rst_n(rst_n),
            .coef_i(lane_coef[l]), .samp_i(lane_samp[l]), .prod_o(lane_prod[l])
        );
    end

    typedef struct packed {
        logic [DAC_W-1:0] dac;
    } out_t;

    logic signed [SUM_W-1:0] sum_d;
    out_t out_d, out_q;

    always_comb begin
        sum_d = '0;
        for (int l = 0; l < NUM_LANES; l++) begin
            sum_d = sum_d + SUM_W'(lane_prod[l]);
        end
        out_d = out_q;
        if (sum_d < 0)
            out_d.dac = '0;
        else if (sum_d > $signed(SUM_W'(DAC_MAX)))
            out_d.dac = DAC_W'(DAC_MAX);
        else
            out_d.dac = sum_d[DAC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{dac: DAC_W'(MID)};
        else        out_q <= out_d;
    end

    assign dac_code = out_q.dac;

    // R9: an over-range sum clamps to full scale on the next sample
    p_sat_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_d > $signed(SUM_W'(DAC_MAX))) |=> (dac_code == DAC_W'(DAC_MAX)));

    // R9: a negative sum clamps to zero on the next sample
    p_sat_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_d < 0) |=> (dac_code == '0));

endmodule

// File: tb/iq_offset_mod_bench.sv
module iq_offset_mod_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stage_en = 1'b0;
    logic        commit_en = 1'b0;
    logic [31:0] tune_word = '0;
    logic [7:0]  i_coef = '0;
    logic [7:0]  q_coef = '0;
    logic [13:0] dac_code;

    iq_offset_mod u_iq_offset_mod (
        .clk(clk), .rst_n(rst_n), .stage_en(stage_en), .commit_en(commit_en),
        .tune_word(tune_word), .i_coef(i_coef), .q_coef(q_coef), .dac_code(dac_code)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail = 0;
    string cur_req = "R4";
    bit seen_hi = 0;
    bit seen_lo = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
        end
    endtask

    // Independent model of the requirement formulas (R3, R4, R9)
    function automatic int sig(int k);
        int kk;
        int x;
        int m;
        kk = k & 1023;
        x  = kk & 511;
        m  = (x * (512 - x) * 127) / 65536;
        return (kk < 512) ? m : -m;
    endfunction

    function automatic int model_out(int ci, int cq, int p);
        int v;
        v = 8192 + ci * sig(p) + cq * sig(p + 256);
        if (v < 0) v = 0;
        if (v > 16383) v = 16383;
        return v;
    endfunction

    typedef struct {
        int    due;
        int    val;
        string tag;
    } item_t;
    item_t sb[$];

    // Architectural state mirror (R2, R6, R7, R8)
    int          cyc = 0;
    logic [31:0] ph = '0;
    logic [31:0] ph_old;
    logic [31:0] a_ftw = '0, s_ftw = '0;
    int          a_i = 0, a_q = 0, s_i = 0, s_q = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; ph = '0; a_ftw = '0; s_ftw = '0;
            a_i = 0; a_q = 0; s_i = 0; s_q = 0;
            sb.delete();
        end else begin
            cyc++;
            ph_old = ph;
            ph = ph + a_ftw;
            if (commit_en) begin
                a_ftw = s_ftw; a_i = s_i; a_q = s_q;
            end
            if (stage_en) begin
                s_ftw = tune_word; s_i = int'($signed(i_coef)); s_q = int'($signed(q_coef));
            end
            sb.push_back('{due: cyc + 5, val: model_out(a_i, a_q, int'(ph_old[31:22])), tag: cur_req});
        end
    end

    // Monitor: samples mid-high phase, away from both edges
    always @(posedge clk) begin
        item_t it;
        #5;
        if (!rst_n) begin
            chk(dac_code == 14'd8192, "R1", int'(dac_code), 8192);
        end else begin
            if (cyc >= 1 && cyc <= 5) chk(dac_code == 14'd8192, "R1", int'(dac_code), 8192);
            while (sb.size() > 0 && sb[0].due == cyc) begin
                it = sb.pop_front();
                chk(int'(dac_code) == it.val, it.tag, int'(dac_code), it.val);
            end
            if (dac_code == 14'd16383) seen_hi = 1;
            if (dac_code == 14'd0)     seen_lo = 1;
        end
    end

    task automatic stage(input logic [31:0] f, input int ci, input int cq);
        @(negedge clk);
        tune_word = f; i_coef = 8'(ci); q_coef = 8'(cq); stage_en = 1'b1;
        @(negedge clk);
        stage_en = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        commit_en = 1'b1;
        @(negedge clk);
        commit_en = 1'b0;
    endtask

    task automatic stage_and_commit(input logic [31:0] f, input int ci, input int cq);
        @(negedge clk);
        tune_word = f; i_coef = 8'(ci); q_coef = 8'(cq); stage_en = 1'b1; commit_en = 1'b1;
        @(negedge clk);
        stage_en = 1'b0; commit_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    bit done = 0;

    initial begin
        longint acc;
        // R1: reset state
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        idle(12);

        // R2 R3 R4 R5: one table step per clock, modest I
        cur_req = "R4";
        stage(32'h0040_0000, 40, 0);
        commit();
        idle(20);
        // R10: exact mean over a full period
        acc = 0;
        for (int k = 0; k < 1024; k++) begin
            @(posedge clk); #5;
            acc += longint'(dac_code);
        end
        chk(acc == 64'd8388608, "R10", int'(acc), 8388608);

        // R2 R5: mixed coefficients, odd step
        cur_req = "R5";
        stage(32'h00C0_3039, -50, 30);
        commit();
        idle(300);

        // R6: staging without commit leaves output on the old set
        cur_req = "R6";
        stage(32'h0123_4567, 127, 127);
        idle(80);

        // R7 R9: commit of a set that clamps both ways
        cur_req = "R7";
        commit();
        idle(400);
        chk(seen_hi, "R9", int'(seen_hi), 1);
        chk(seen_lo, "R9", int'(seen_lo), 1);

        // R8: stage and commit on the same clock
        cur_req = "R8";
        stage(32'h0080_0000, 20, -20);
        stage_and_commit(32'h0200_0000, -100, 60);
        idle(60);
        cur_req = "R7";
        commit();
        idle(100);

        // R2: zero step holds phase, R9 with both coefficients at minimum
        cur_req = "R9";
        stage(32'h0000_0000, -128, -128);
        commit();
        idle(40);

        // R1: reset applied again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        idle(4);
        rst_n = 1'b1;
        cur_req = "R4";
        idle(10);
        stage(32'h0100_0000, 33, -77);
        commit();
        idle(200);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule